// File: doc/BRIEF.md
# Per-Server Interrupt Presentation Controller

This block holds the interrupt that is being presented to each of a small set of processors ("servers"). For every server it keeps a 32-bit request word, whose top byte is the processor's current priority and whose low 24 bits name the source being presented. It also keeps a pending-priority byte and an inter-processor-interrupt (IPI) priority byte. Lower numbers are more favoured. Only one source is held per server. A better offer displaces the held source and sends it back to the source side as a reject.

A source controller offers deliveries as (server, source, priority), and the block either takes or refuses each one. Processors issue four operations: set current priority, set IPI priority for any target server, accept, and end-of-interrupt. The block drives one interrupt line per server. It sends single-cycle reject, resend and end-of-interrupt notifications back to the source side.

Reject notifications use two lanes. The operation lane carries a reject caused by an operation. The delivery lane carries a reject caused by a delivery. In one cycle the operation is applied before the delivery. The IPI uses the reserved source number 2.

Top module: `intr_present_ctl`

## Requirements
- R1: After reset every server has current priority 0x00, source field 0, pending priority 0x00 and IPI priority 0xFF. Every interrupt line is low and no notification is pulsing, so an accept issued right after reset returns 0x00000000.
- R2: A delivery is refused, with its own source number placed on the delivery reject lane, in two cases: its priority is greater than or equal to the server's current priority, or a source is held whose pending priority is less than or equal to the offered one. A delivery whose source number is 0 is ignored, with no reject and no change.
- R3: A delivery that is not refused puts any held source on the delivery reject lane, then stores the new source and priority and raises that server's line. A server's line is high exactly while its source field is nonzero.
- R4: Accept (op code 2) returns the full request word {current priority, source} on op_rdata. It lowers the line, clears the source field and loads the current priority with the pending priority.
- R5: Set current priority (op code 0, value in op_data[7:0]) to a value smaller than the present one withdraws a held source whose pending priority is greater than or equal to the new value. The source field is cleared, the line is lowered, and the source goes out on the operation reject lane.
- R6: Setting current priority to an equal or larger value while nothing is held pulses resend with the server index. Before that pulse, if the IPI priority is below the new current priority, the IPI is presented as in R7.
- R7: Set IPI priority (op code 1, target server in op_target, value in op_data[7:0]) stores the value. If the value is below the target's current priority, the IPI is offered, and it is ignored if a held source has a pending priority less than or equal to the value. Otherwise any held source goes out on the operation reject lane, source 2 is loaded with the IPI priority as pending priority, and the line is raised.
- R8: End-of-interrupt (op code 3) copies op_data[31:24] into the current priority and pulses the EOI output with op_data[23:0]. If no source is held afterwards, it performs the resend of R6.
- R9: A set-IPI-priority operation whose target index is not below the server count pulses op_err and changes no state and no line.
- R10: All outputs are registered and change at the clock edge that samples the stimulus. When an operation and a delivery reach the same server in one cycle, the operation takes effect first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dlv_valid | input | 1 | Delivery offer present |
| dlv_server | input | SW | Server the delivery is for |
| dlv_src | input | SRCW | Offered source number |
| dlv_prio | input | PRIW | Offered priority |
| op_valid | input | 1 | Processor operation present |
| op_code | input | 2 | 0 set priority, 1 set IPI priority, 2 accept, 3 end-of-interrupt |
| op_server | input | SW | Issuing server |
| op_target | input | TGTW | Target server for set IPI priority |
| op_data | input | PRIW+SRCW | Operation value |
| op_rdata | output | PRIW+SRCW | Word returned by the last accept |
| op_err | output | 1 | Pulse: set IPI priority with a bad target |
| irq_out | output | NSRV | Interrupt line per server |
| rejo_valid | output | 1 | Pulse: reject caused by an operation |
| rejo_src | output | SRCW | Source rejected by an operation |
| rejd_valid | output | 1 | Pulse: reject caused by a delivery |
| rejd_src | output | SRCW | Source rejected by a delivery |
| rsnd_valid | output | 1 | Pulse: resend request |
| rsnd_server | output | SW | Server requesting the resend |
| eoi_valid | output | 1 | Pulse: end-of-interrupt forwarded |
| eoi_src | output | SRCW | Source being ended |

## Verification
Each result appears one clock edge after its stimulus is sampled: the interrupt lines, both reject lanes, the resend and EOI pulses, op_err and the accept word. The bench changes inputs on the falling edge and compares every output at the next falling edge, which is the only cycle a pulse is high. Back-to-back steps then show that a pulse drops when nothing new causes it. A reference model that runs in step with the design supplies the expected values for directed corner cases and for a long seeded random mix.

// File: rtl/intr_present_ctl.sv
module intr_present_ctl #(
  parameter int NSRV = 4,
  parameter int SRCW = 24,
  parameter int PRIW = 8,
  parameter int TGTW = 8,
  parameter logic [SRCW-1:0] IPI_SRC = 2,
  localparam int SW = (NSRV > 1) ? $clog2(NSRV) : 1,
  localparam int XW = PRIW + SRCW
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            dlv_valid,
  input  logic [SW-1:0]   dlv_server,
  input  logic [SRCW-1:0] dlv_src,
  input  logic [PRIW-1:0] dlv_prio,
  input  logic            op_valid,
  input  logic [1:0]      op_code,
  input  logic [SW-1:0]   op_server,
  input  logic [TGTW-1:0] op_target,
  input  logic [XW-1:0]   op_data,
  output logic [XW-1:0]   op_rdata,
  output logic            op_err,
  output logic [NSRV-1:0] irq_out,
  output logic            rejo_valid,
  output logic [SRCW-1:0] rejo_src,
  output logic            rejd_valid,
  output logic [SRCW-1:0] rejd_src,
  output logic            rsnd_valid,
  output logic [SW-1:0]   rsnd_server,
  output logic            eoi_valid,
  output logic [SRCW-1:0] eoi_src
);

  typedef enum logic [1:0] {OP_CPPR = 2'd0, OP_IPI = 2'd1, OP_ACC = 2'd2, OP_EOI = 2'd3} op_t;

  typedef struct packed {
    logic [PRIW-1:0] cppr;
    logic [SRCW-1:0] xisr;
    logic [PRIW-1:0] pend;
    logic [PRIW-1:0] mfrr;
    logic            irq;
  } srv_t;

  srv_t st_q [NSRV];
  srv_t st_d [NSRV];

  logic            rov_d, rdv_d, rsv_d, eov_d, err_d, rd_we;
  logic [SRCW-1:0] ros_d, rds_d, eos_d;
  logic [SW-1:0]   rss_d;
  logic [XW-1:0]   rd_d;
  logic            tgt_ok;

  assign tgt_ok = int'(op_target) < NSRV;

  function automatic void chk_ipi(inout srv_t v, inout logic rv, inout logic [SRCW-1:0] rs);
    if (!(v.xisr != '0 && v.pend <= v.mfrr)) begin
      if (v.xisr != '0) begin
        rv = 1'b1;
        rs = v.xisr;
      end
      v.xisr = IPI_SRC;
      v.pend = v.mfrr;
      v.irq  = 1'b1;
    end
  endfunction

  function automatic void resend(inout srv_t v, inout logic rv, inout logic [SRCW-1:0] rs);
    if (v.mfrr < v.cppr) chk_ipi(v, rv, rs);
  endfunction

  always_comb begin
    rov_d = 1'b0; ros_d = '0;
    rdv_d = 1'b0; rds_d = '0;
    rsv_d = 1'b0; rss_d = '0;
    eov_d = 1'b0; eos_d = '0;
    rd_we = 1'b0; rd_d = '0;
    err_d = op_valid && (op_code == OP_IPI) && !tgt_ok;
    for (int s = 0; s < NSRV; s++) begin
      srv_t v;
      logic [PRIW-1:0] nc;
      v = st_q[s];
      nc = op_data[PRIW-1:0];
      if (op_valid && op_server == SW'(s)) begin
        case (op_code)
          OP_CPPR: begin
            if (nc < v.cppr) begin
              v.cppr = nc;
              if (v.xisr != '0 && nc <= v.pend) begin
                rov_d = 1'b1;
                ros_d = v.xisr;
                v.xisr = '0;
                v.irq = 1'b0;
              end
            end else begin
              v.cppr = nc;
              if (v.xisr == '0) begin
                resend(v, rov_d, ros_d);
                rsv_d = 1'b1;
                rss_d = SW'(s);
              end
            end
          end
          OP_ACC: begin
            rd_we = 1'b1;
            rd_d = {v.cppr, v.xisr};
            v.irq = 1'b0;
            v.cppr = v.pend;
            v.xisr = '0;
          end
          OP_EOI: begin
            v.cppr = op_data[XW-1:SRCW];
            eov_d = 1'b1;
            eos_d = op_data[SRCW-1:0];
            if (v.xisr == '0) begin
              resend(v, rov_d, ros_d);
              rsv_d = 1'b1;
              rss_d = SW'(s);
            end
          end
          default: ;
        endcase
      end
      if (op_valid && op_code == OP_IPI && tgt_ok && op_target == TGTW'(s)) begin
        v.mfrr = nc;
        if (v.mfrr < v.cppr) chk_ipi(v, rov_d, ros_d);
      end
      if (dlv_valid && dlv_src != '0 && dlv_server == SW'(s)) begin
        if (dlv_prio >= v.cppr || (v.xisr != '0 && v.pend <= dlv_prio)) begin
          rdv_d = 1'b1;
          rds_d = dlv_src;
        end else begin
          if (v.xisr != '0) begin
            rdv_d = 1'b1;
            rds_d = v.xisr;
          end
          v.xisr = dlv_src;
          v.pend = dlv_prio;
          v.irq = 1'b1;
        end
      end
      st_d[s] = v;
    end
    if (dlv_valid && dlv_src != '0 && int'(dlv_server) >= NSRV) begin
      rdv_d = 1'b1;
      rds_d = dlv_src;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int s = 0; s < NSRV; s++) begin
        st_q[s] <= '{cppr: '0, xisr: '0, pend: '0, mfrr: '1, irq: 1'b0};
      end
      rejo_valid <= 1'b0; rejo_src <= '0;
      rejd_valid <= 1'b0; rejd_src <= '0;
      rsnd_valid <= 1'b0; rsnd_server <= '0;
      eoi_valid <= 1'b0; eoi_src <= '0;
      op_err <= 1'b0; op_rdata <= '0;
    end else begin
      for (int s = 0; s < NSRV; s++) st_q[s] <= st_d[s];
      rejo_valid <= rov_d; rejo_src <= ros_d;
      rejd_valid <= rdv_d; rejd_src <= rds_d;
      rsnd_valid <= rsv_d; rsnd_server <= rss_d;
      eoi_valid <= eov_d; eoi_src <= eos_d;
      op_err <= err_d;
      if (rd_we) op_rdata <= rd_d;
    end
  end

  logic [NSRV-1:0] held;
  for (genvar g = 0; g < NSRV; g++) begin : g_out
    assign irq_out[g] = st_q[g].irq;
    assign held[g] = st_q[g].xisr != '0;
  end

  // R3
  irq_held_chk: assert property (@(posedge clk) disable iff (!rst_n) irq_out == held);

  // R4
  acc_lower_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_code == OP_ACC && !(dlv_valid && dlv_server == op_server))
    |=> (irq_out[$past(op_server)] == 1'b0));

  // R9
  bad_tgt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_code == OP_IPI && !tgt_ok && !dlv_valid) |=> (op_err && $stable(irq_out)));

  // R2
  dlv_rej_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dlv_valid && !op_valid && dlv_src != '0 && dlv_prio >= st_q[dlv_server].cppr)
    |=> (rejd_valid && rejd_src == $past(dlv_src) && $stable(irq_out)));

  // R8
  eoi_fwd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_code == OP_EOI) |=> (eoi_valid && eoi_src == $past(op_data[SRCW-1:0])));

endmodule

// File: tb/sim_intr_present_ctl.sv
`timescale 1ns/1ps
module sim_intr_present_ctl;
  localparam int NS = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic dlv_valid = 0, op_valid = 0;
  logic [1:0] dlv_server = 0, op_server = 0, op_code = 0;
  logic [23:0] dlv_src = 0;
  logic [7:0] dlv_prio = 0, op_target = 0;
  logic [31:0] op_data = 0, op_rdata;
  logic op_err, rejo_valid, rejd_valid, rsnd_valid, eoi_valid;
  logic [NS-1:0] irq_out;
  logic [23:0] rejo_src, rejd_src, eoi_src;
  logic [1:0] rsnd_server;

  always #2.5 clk = ~clk;

  intr_present_ctl u0 (.clk, .rst_n, .dlv_valid, .dlv_server, .dlv_src, .dlv_prio,
    .op_valid, .op_code, .op_server, .op_target, .op_data, .op_rdata, .op_err, .irq_out,
    .rejo_valid, .rejo_src, .rejd_valid, .rejd_src, .rsnd_valid, .rsnd_server,
    .eoi_valid, .eoi_src);

  int checks = 0, errors = 0;

  logic [7:0] mc [NS], mp [NS], mm [NS];
  logic [23:0] mx [NS];
  logic e_rov, e_rdv, e_rsv, e_eov, e_err;
  logic [23:0] e_ros, e_rds, e_eos;
  logic [1:0] e_rss;
  logic [31:0] e_rd;

  task automatic chk(string tag, string nm, logic [31:0] a, logic [31:0] e);
    checks++;
    if (a !== e) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, nm, a, e);
    end
  endtask

  task automatic m_ipi(int s);
    if (!(mx[s] != 0 && mp[s] <= mm[s])) begin
      if (mx[s] != 0) begin e_rov = 1; e_ros = mx[s]; end
      mx[s] = 2; mp[s] = mm[s];
    end
  endtask

  task automatic m_resend(int s);
    if (mm[s] < mc[s]) m_ipi(s);
    e_rsv = 1; e_rss = 2'(s);
  endtask

  task automatic model(bit ov, int oc, int os, int ot, logic [31:0] od,
                       bit dv, int ds, logic [23:0] dsrc, logic [7:0] dp);
    e_rov = 0; e_ros = 0; e_rdv = 0; e_rds = 0; e_rsv = 0; e_rss = 0;
    e_eov = 0; e_eos = 0; e_err = ov && oc == 1 && ot >= NS;
    if (ov) begin
      case (oc)
        0: begin
          if (od[7:0] < mc[os]) begin
            mc[os] = od[7:0];
            if (mx[os] != 0 && od[7:0] <= mp[os]) begin
              e_rov = 1; e_ros = mx[os]; mx[os] = 0;
            end
          end else begin
            mc[os] = od[7:0];
            if (mx[os] == 0) m_resend(os);
          end
        end
        1: if (ot < NS) begin
          mm[ot] = od[7:0];
          if (mm[ot] < mc[ot]) m_ipi(ot);
        end
        2: begin
          e_rd = {mc[os], mx[os]};
          mc[os] = mp[os]; mx[os] = 0;
        end
        default: begin
          mc[os] = od[31:24];
          e_eov = 1; e_eos = od[23:0];
          if (mx[os] == 0) m_resend(os);
        end
      endcase
    end
    if (dv && dsrc != 0) begin
      if (dp >= mc[ds] || (mx[ds] != 0 && mp[ds] <= dp)) begin
        e_rdv = 1; e_rds = dsrc;
      end else begin
        if (mx[ds] != 0) begin e_rdv = 1; e_rds = mx[ds]; end
        mx[ds] = dsrc; mp[ds] = dp;
      end
    end
  endtask

  task automatic step(bit ov, int oc, int os, int ot, logic [31:0] od,
                      bit dv, int ds, logic [23:0] dsrc, logic [7:0] dp, string tag);
    logic [NS-1:0] ei;
    op_valid = ov; op_code = 2'(oc); op_server = 2'(os); op_target = 8'(ot); op_data = od;
    dlv_valid = dv; dlv_server = 2'(ds); dlv_src = dsrc; dlv_prio = dp;
    model(ov, oc, os, ot, od, dv, ds, dsrc, dp);
    @(negedge clk);
    op_valid = 0; dlv_valid = 0;
    for (int s = 0; s < NS; s++) ei[s] = (mx[s] != 0);
    chk(tag, "irq_out", 32'(irq_out), 32'(ei));
    chk(tag, "rejo_valid", 32'(rejo_valid), 32'(e_rov));
    if (e_rov) chk(tag, "rejo_src", 32'(rejo_src), 32'(e_ros));
    chk(tag, "rejd_valid", 32'(rejd_valid), 32'(e_rdv));
    if (e_rdv) chk(tag, "rejd_src", 32'(rejd_src), 32'(e_rds));
    chk(tag, "rsnd_valid", 32'(rsnd_valid), 32'(e_rsv));
    if (e_rsv) chk(tag, "rsnd_server", 32'(rsnd_server), 32'(e_rss));
    chk(tag, "eoi_valid", 32'(eoi_valid), 32'(e_eov));
    if (e_eov) chk(tag, "eoi_src", 32'(eoi_src), 32'(e_eos));
    chk(tag, "op_err", 32'(op_err), 32'(e_err));
    chk(tag, "op_rdata", op_rdata, e_rd);
  endtask

  initial begin
    #(5.0 * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240517));
    for (int s = 0; s < NS; s++) begin mc[s] = 0; mx[s] = 0; mp[s] = 0; mm[s] = 8'hFF; end
    e_rd = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    chk("R1", "irq_out after reset", 32'(irq_out), 0);
    chk("R1", "rejo_valid after reset", 32'(rejo_valid), 0);
    step(1, 2, 0, 0, 0, 0, 0, 0, 0, "R1");
    chk("R1", "accept word", op_rdata, 32'h0);
    step(0, 0, 0, 0, 0, 1, 0, 24'd16, 8'd5, "R2");
    step(1, 0, 0, 0, 32'hFF, 0, 0, 0, 0, "R6");
    step(0, 0, 0, 0, 0, 1, 0, 24'd16, 8'd5, "R3");
    step(0, 0, 0, 0, 0, 1, 0, 24'd17, 8'd5, "R2");
    step(0, 0, 0, 0, 0, 1, 0, 24'd18, 8'd3, "R3");
    step(1, 2, 0, 0, 0, 0, 0, 0, 0, "R4");
    chk("R4", "accept word literal", op_rdata, 32'hFF000012);
    step(1, 3, 0, 0, 32'hFF000012, 0, 0, 0, 0, "R8");
    step(0, 0, 0, 0, 0, 1, 0, 24'd16, 8'd4, "R3");
    step(1, 0, 0, 0, 32'h06, 0, 0, 0, 0, "R5");
    step(1, 0, 0, 0, 32'h04, 0, 0, 0, 0, "R5");
    step(1, 1, 0, 1, 32'h03, 0, 0, 0, 0, "R7");
    step(1, 0, 1, 0, 32'hFF, 0, 0, 0, 0, "R6");
    step(0, 0, 0, 0, 0, 1, 1, 24'd20, 8'd2, "R3");
    step(1, 1, 0, 1, 32'h01, 0, 0, 0, 0, "R7");
    step(1, 1, 0, 1, 32'h05, 0, 0, 0, 0, "R7");
    step(1, 1, 0, 9, 32'h00, 0, 0, 0, 0, "R9");
    chk("R9", "op_err literal", 32'(op_err), 1);
    step(1, 0, 0, 0, 32'hFF, 1, 0, 24'd16, 8'd7, "R10");
    step(0, 0, 0, 0, 0, 1, 0, 24'd0, 8'd1, "R2");
    step(1, 3, 2, 0, 32'h10000015, 0, 0, 0, 0, "R8");
    for (int i = 0; i < 3000; i++) begin
      bit ov, dv;
      int oc, ot;
      logic [31:0] od;
      logic [23:0] ds;
      logic [7:0] dp;
      ov = ($urandom % 3) != 0;
      dv = ($urandom % 2) != 0;
      oc = $urandom % 4;
      ot = (($urandom % 10) == 0) ? 4 + ($urandom % 4) : $urandom % NS;
      od = {8'(($urandom % 5 == 0) ? 8'hFF : 8'($urandom % 8)), 24'(16 + $urandom % 6)};
      if (oc != 3) od = 32'(($urandom % 6 == 0) ? 8'hFF : 8'($urandom % 8));
      ds = (($urandom % 8) == 0) ? 24'd0 : 24'(16 + $urandom % 8);
      dp = 8'($urandom % 8);
      step(ov, oc, $urandom % NS, ot, od, dv, $urandom % NS, ds, dp, "R10");
    end
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule